// File: doc/BRIEF.md
# Single-Sideband Audio Demodulator Pipeline

This block turns a multiplexed stream of baseband samples into audio codes for an 8-bit DAC. The stream carries I and Q samples one after the other. I samples are held in a delay line for 32 pairs. Q samples run through a 64-tap FIR that rotates phase by a quarter turn with a flat magnitude response. The delayed I and the rotated Q are summed or differenced to keep one sideband. That result then feeds a 64-tap audio FIR. Software picks one of four coefficient sets for this filter. The filtered value is rounded, clamped to 8 bits and shifted to offset binary.

Both filters share one 24x24 multiplier with a 48-bit accumulator, which handles one tap per clock. Each Q sample starts a fixed 130-cycle job that yields one audio code. At the intended sample rate (about 32k samples per second, or about 16k pairs per second) the sample period is far longer than this job. The sideband and filter choices are captured when a Q sample is accepted. The sample histories are never flushed, so a change of choice is seamless.

Top module: `ssb_demod`

## Requirements
- R1: After reset, dac_code is 0x80, dac_valid is 0, all sample histories hold zero, and the first accepted sample is taken as I.
- R2: Accepted samples (smp_valid high at a clock edge) alternate I, Q, I, Q. smp_data is 14-bit two's complement.
- R3: For pair p, the quadrature term is H = floor(sum over n=0..63 of h[n]*Q[p-n] / 2^15). Here h[n] = 0 when n-32 is even, and otherwise h[n] = 20861/(n-32) with integer division truncated toward zero.
- R4: The in-phase term paired with H for pair p is I[p-32], the I sample accepted 32 pairs earlier.
- R5: The sideband control lower_sb selects S = I[p-32] + H when 0 and S = I[p-32] - H when 1.
- R6: The audio filter forms A = sum over n=0..63 of c[n]*S[p-n]. The filter select code chooses c as follows. Code 0 gives 5461 for n<6. Code 1 gives 4096 for n<8. Code 2 gives 2978 for n<11. Code 3 gives T[n mod 16] for n<40, where T = 1638,1513,1158,627,0,-627,-1158,-1513,-1638,-1513,-1158,-627,0,627,1158,1513. Every other tap is 0.
- R7: The output is y = floor((A + 2^20) / 2^21), clamped to the range -128..127, and dac_code = y + 128.
- R8: dac_valid is a one-cycle pulse exactly 130 clock edges after the edge that accepts the Q sample. dac_code changes only together with that pulse.
- R9: lower_sb and band_sel are sampled at the edge that accepts a Q sample. Changes at other times do not alter the result in flight. Histories are not cleared when a choice changes.
- R10: An I sample may arrive while a result is in flight without changing that result. A Q sample must not arrive before the previous pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_data | input | 14 | Signed baseband sample, I and Q alternating |
| lower_sb | input | 1 | 0 keeps the upper sideband, 1 the lower |
| band_sel | input | 2 | Audio filter coefficient set |
| dac_code | output | 8 | Offset-binary audio code |
| dac_valid | output | 1 | Pulse marking a new dac_code |

## Verification
The bench drives a lone Q impulse and a lone I impulse. This exposes any wrong tap sign, an odd-offset tap that is not zeroed, and a delay line that is one pair long or short; each of these shifts or reshapes the impulse response. It changes the sideband and filter choices in the middle of a job and inserts the next I sample during the job. A design that reads these choices late, or reads the delay line late, would then produce a wrong code for that pair. Constant full-scale inputs of both signs drive the result into both rails. A 1 kHz tone runs through the band-pass set, where a wrong cosine entry or a wrong tap count shows up at once. Every code is also timed against the 130-edge latency and checked to be a single-cycle pulse.

// File: rtl/ssb_demod.sv
`timescale 1ns/1ps
module ssb_demod #(
  parameter int DW       = 14,
  parameter int CW       = 24,
  parameter int AW       = 48,
  parameter int TAPS     = 64,
  parameter int DLY      = 32,
  parameter int HSH      = 15,
  parameter int OSH      = 21,
  parameter int OW       = 8,
  parameter int HGAIN    = 20861,
  parameter int BOX_GAIN = 32768,
  parameter int LEN_W    = 6,
  parameter int LEN_M    = 8,
  parameter int LEN_N    = 11,
  parameter int BP_LEN   = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_data,
  input  logic                 lower_sb,
  input  logic [1:0]           band_sel,
  output logic [OW-1:0]        dac_code,
  output logic                 dac_valid
);
  localparam int KW = $clog2(TAPS);
  localparam logic signed [AW-1:0] RND  = AW'(1 << (OSH-1));
  localparam logic signed [AW-1:0] OMAX = AW'((1 << (OW-1)) - 1);
  localparam logic signed [AW-1:0] OMIN = -OMAX - AW'(1);

  typedef enum logic [2:0] {S_IDLE, S_HIL, S_SUM, S_LPF, S_OUT} st_t;

  function automatic logic signed [CW-1:0] hil_coef(input int n);
    int d;
    d = n - DLY;
    if (d % 2 == 0) return '0;
    return CW'(HGAIN / d);
  endfunction

  function automatic int bp_cos(input int m);
    case (m)
      0: return 1638;   1: return 1513;   2: return 1158;   3: return 627;
      4: return 0;      5: return -627;   6: return -1158;  7: return -1513;
      8: return -1638;  9: return -1513;  10: return -1158; 11: return -627;
      12: return 0;     13: return 627;   14: return 1158;  default: return 1513;
    endcase
  endfunction

  function automatic logic signed [CW-1:0] lp_coef(input int s, input int n);
    int v;
    case (s)
      0: v = (n < LEN_W) ? BOX_GAIN / LEN_W : 0;
      1: v = (n < LEN_M) ? BOX_GAIN / LEN_M : 0;
      2: v = (n < LEN_N) ? BOX_GAIN / LEN_N : 0;
      default: v = (n < BP_LEN) ? bp_cos(n % 16) : 0;
    endcase
    return CW'(v);
  endfunction

  logic signed [CW-1:0] hc [TAPS];
  logic signed [CW-1:0] lc [4][TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign hc[g] = hil_coef(g);
    for (genvar s = 0; s < 4; s++) begin : g_set
      assign lc[s][g] = lp_coef(s, g);
    end
  end

  logic signed [CW-1:0] ihist [DLY+1];
  logic signed [CW-1:0] qhist [TAPS];
  logic signed [CW-1:0] shist [TAPS];
  logic signed [CW-1:0] i_cur;
  logic signed [AW-1:0] acc;
  logic [KW-1:0]        k;
  logic                 is_q, lsb_q, busy;
  logic [1:0]           sel_q;
  st_t                  st;

  wire i_take = smp_valid & ~is_q;
  wire q_take = smp_valid &  is_q;
  wire signed [CW-1:0] smp_ext = $signed({{(CW-DW){smp_data[DW-1]}}, smp_data});

  wire signed [CW-1:0] mac_c = (st == S_HIL) ? hc[k]    : lc[sel_q][k];
  wire signed [CW-1:0] mac_d = (st == S_HIL) ? qhist[k] : shist[k];
  wire signed [AW-1:0] prod  = $signed({{(AW-CW){mac_c[CW-1]}}, mac_c})
                             * $signed({{(AW-CW){mac_d[CW-1]}}, mac_d});

  wire signed [AW-1:0] acc_h = acc >>> HSH;
  wire signed [CW-1:0] hil_y = acc_h[CW-1:0];
  wire signed [CW-1:0] s_new = lsb_q ? i_cur - hil_y : i_cur + hil_y;

  wire signed [AW-1:0] rnd   = (acc + RND) >>> OSH;
  wire signed [AW-1:0] clmp  = (rnd > OMAX) ? OMAX : (rnd < OMIN) ? OMIN : rnd;
  wire        [OW-1:0] code  = clmp[OW-1:0] ^ {1'b1, {(OW-1){1'b0}}};

  wire last = (k == KW'(TAPS-1));

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j <= DLY; j++) ihist[j] <= '0;
      for (int j = 0; j < TAPS; j++) begin
        qhist[j] <= '0;
        shist[j] <= '0;
      end
      i_cur     <= '0;
      acc       <= '0;
      k         <= '0;
      is_q      <= 1'b0;
      lsb_q     <= 1'b0;
      sel_q     <= '0;
      st        <= S_IDLE;
      dac_code  <= {1'b1, {(OW-1){1'b0}}};
      dac_valid <= 1'b0;
    end else begin
      dac_valid <= 1'b0;
      if (smp_valid) is_q <= ~is_q;
      if (i_take) begin
        ihist[0] <= smp_ext;
        for (int j = 1; j <= DLY; j++) ihist[j] <= ihist[j-1];
      end
      if (q_take) begin
        qhist[0] <= smp_ext;
        for (int j = 1; j < TAPS; j++) qhist[j] <= qhist[j-1];
        i_cur <= ihist[DLY];
        lsb_q <= lower_sb;
        sel_q <= band_sel;
        acc   <= '0;
        k     <= '0;
        st    <= S_HIL;
      end else begin
        case (st)
          S_HIL, S_LPF: begin
            acc <= acc + prod;
            k   <= k + KW'(1);
            if (last) st <= (st == S_HIL) ? S_SUM : S_OUT;
          end
          S_SUM: begin
            shist[0] <= s_new;
            for (int j = 1; j < TAPS; j++) shist[j] <= shist[j-1];
            acc <= '0;
            k   <= '0;
            st  <= S_LPF;
          end
          S_OUT: begin
            dac_code  <= code;
            dac_valid <= 1'b1;
            st        <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ssb_demod_chk.sv
`timescale 1ns/1ps
module ssb_demod_chk #(
  parameter int TAPS = 64,
  parameter int OW   = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          is_q,
  input logic          busy,
  input logic [OW-1:0] dac_code,
  input logic          dac_valid
);
  localparam int LAT = 2*TAPS + 2;
  localparam int LW  = $clog2(LAT + 2);

  logic [LW-1:0] lat;
  logic          pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat  <= '0;
      pend <= 1'b0;
    end else begin
      if (smp_valid && is_q) begin
        lat  <= '0;
        pend <= 1'b1;
      end else begin
        if (pend) lat <= lat + LW'(1);
        if (dac_valid) pend <= 1'b0;
      end
    end
  end

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |=> !dac_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_valid |-> $stable(dac_code));
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |-> (lat == LW'(LAT)));
  assert_one_per_q_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |-> pend);
  assert_q_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && is_q) |-> !busy);
endmodule

bind ssb_demod ssb_demod_chk #(.TAPS(TAPS), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .is_q(is_q),
  .busy(busy), .dac_code(dac_code), .dac_valid(dac_valid));

// File: tb/sim_ssb_demod.sv
`timescale 1ns/1ps
module sim_ssb_demod;
  logic        clk = 1'b0, rst_n = 1'b0, smp_valid = 1'b0, lower_sb = 1'b0;
  logic [13:0] smp_data = '0;
  logic [1:0]  band_sel = '0;
  logic [7:0]  dac_code;
  logic        dac_valid;

  int n_cmp = 0, n_bad = 0;
  bit done = 0, i_pre = 0;
  int qm[64], sm[64], im[33];
  int cosv[16] = '{1638,1513,1158,627,0,-627,-1158,-1513,-1638,-1513,-1158,-627,0,627,1158,1513};

  always #2.5 clk = ~clk;

  ssb_demod u0 (.clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
                .lower_sb(lower_sb), .band_sel(band_sel), .dac_code(dac_code), .dac_valid(dac_valid));

  function automatic int hval(int n);
    int off = n - 32;
    if (off % 2 == 0) return 0;
    return 20861 / off;
  endfunction

  function automatic int lval(int s, int n);
    if (s == 0) return (n < 6)  ? 5461 : 0;
    if (s == 1) return (n < 8)  ? 4096 : 0;
    if (s == 2) return (n < 11) ? 2978 : 0;
    return (n < 40) ? cosv[n % 16] : 0;
  endfunction

  function automatic void push_i(int v);
    for (int j = 32; j > 0; j--) im[j] = im[j-1];
    im[0] = v;
  endfunction

  function automatic int model_q(int qv, int s, bit lsb);
    longint a;
    int h, tot;
    for (int j = 63; j > 0; j--) qm[j] = qm[j-1];
    qm[0] = qv;
    a = 0;
    for (int j = 0; j < 64; j++) a += longint'(hval(j)) * qm[j];
    h = int'(a >>> 15);
    tot = lsb ? im[32] - h : im[32] + h;
    for (int j = 63; j > 0; j--) sm[j] = sm[j-1];
    sm[0] = tot;
    a = 0;
    for (int j = 0; j < 64; j++) a += longint'(lval(s, j)) * sm[j];
    a = (a + 64'sd1048576) >>> 21;
    if (a > 127) a = 127;
    if (a < -128) a = -128;
    return int'(a) + 128;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_i(input int v);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 14'(v);
    push_i(v);
    @(negedge clk);
    smp_valid = 1'b0;
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic pair(input string tag, input int iv, input int qv,
                      input int nxt, input bit early, input bit chg);
    int exp, cnt, prev, ipos, cpos;
    bit held;
    if (!i_pre) send_i(iv);
    i_pre = 0;
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 14'(qv);
    exp  = model_q(qv, int'(band_sel), lower_sb);
    prev = int'(dac_code);
    ipos = $urandom_range(3, 120);
    cpos = $urandom_range(2, 125);
    @(negedge clk);
    smp_valid = 1'b0;
    cnt = 1; held = 1;
    while (cnt < 400) begin
      @(negedge clk);
      cnt++;
      smp_valid = 1'b0;
      if (dac_valid) break;
      if (int'(dac_code) != prev) held = 0;
      if (early && cnt == ipos) begin
        smp_valid = 1'b1; smp_data = 14'(nxt);
        push_i(nxt);
      end
      if (chg && cnt == cpos) begin
        band_sel = 2'($urandom);
        lower_sb = 1'($urandom);
      end
    end
    chk(cnt == 131, "R8 latency", cnt, 131);
    chk(held, "R8 hold", int'(held), 1);
    chk(int'(dac_code) == exp, tag, int'(dac_code), exp);
    @(negedge clk);
    chk(!dac_valid, "R8 pulse", int'(dac_valid), 0);
    i_pre = early;
  endtask

  function automatic int rnd_amp(int mode);
    if (mode == 0) return $urandom_range(0, 600) - 300;
    if (mode == 1) return $urandom_range(0, 4000) - 2000;
    return $urandom_range(0, 16383) - 8192;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(1000000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int j = 0; j < 64; j++) begin qm[j] = 0; sm[j] = 0; end
    for (int j = 0; j < 33; j++) im[j] = 0;
    repeat (4) @(negedge clk);
    chk(dac_code == 8'h80, "R1 reset code", int'(dac_code), 128);
    chk(!dac_valid, "R1 reset valid", int'(dac_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Q impulse through the quadrature filter, first sample taken as I
    band_sel = 2'd0; lower_sb = 1'b0;
    for (int p = 0; p < 70; p++) pair("R1 R2 R3", 0, (p == 0) ? 4096 : 0, 0, 0, 0);

    // I impulse surfaces 32 pairs later
    band_sel = 2'd1; lower_sb = 1'b1;
    for (int p = 0; p < 40; p++) pair("R4", (p == 0) ? -5000 : 0, 0, 0, 0, 0);

    // random data, selection changes in flight, early I samples
    begin
      int carry, iv, nxt, mode;
      bit early;
      carry = 0;
      for (int p = 0; p < 140; p++) begin
        mode = $urandom_range(0, 2);
        if ($urandom_range(0, 3) == 0) begin
          band_sel = 2'($urandom);
          lower_sb = 1'($urandom);
        end
        iv    = i_pre ? carry : rnd_amp(mode);
        nxt   = rnd_amp(mode);
        early = (p != 139) && ($urandom_range(0, 1) == 1);
        pair("R5 R6 R9 R10", iv, rnd_amp(mode), nxt, early, 1);
        if (early) carry = nxt;
      end
    end

    // full-scale inputs clamp at both rails
    band_sel = 2'd2; lower_sb = 1'b0;
    for (int p = 0; p < 45; p++) pair("R7 high", 8191, 0, 0, 0, 0);
    for (int p = 0; p < 45; p++) pair("R7 low", -8192, 0, 0, 0, 0);

    // 1 kHz tone through the band-pass set, both sidebands
    band_sel = 2'd3; lower_sb = 1'b0;
    for (int p = 0; p < 60; p++) pair("R6 R5 upper", 2*cosv[p % 16], 2*cosv[(p + 4) % 16], 0, 0, 0);
    lower_sb = 1'b1;
    for (int p = 0; p < 30; p++) pair("R6 R5 lower", 2*cosv[p % 16], 2*cosv[(p + 4) % 16], 0, 0, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule